// File: doc/BRIEF.md
# Octal Seven-Segment Word Display Scanner

This block shows one 16-bit word on a six-digit seven-segment display as six octal digits. Only one digit is lit at a time. A step counter moves through the six digit positions. At each step a register takes the segment pattern for that position's 3-bit group and the matching one-hot digit enable, both at the same clock edge. The current step number also leaves the block on a port, so a keypad scanner can share the same timing.

The block does not receive the word it displays. It reads the word itself from a fixed memory address, 077576 octal, through a simple request/grant read port. It asks for the word once per full sweep of the six digits. It holds the request back while the host is running a memory operation. When no grant arrives, the word from the last successful read stays on the display.

Top module: `oct_disp_scan`

## Requirements
- R1: While reset is asserted: scan_idx is 0, dig_en is 6'b000001, seg is 7'h3F (the glyph for 0), the held word is zero, and a read request is pending.
- R2: The step advances by one every STEP_CLKS clocks and wraps from 5 to 0. The first advance happens STEP_CLKS clocks after reset is released. scan_idx never goes above 5.
- R3: dig_en is always one-hot, with bit k set exactly when scan_idx equals k.
- R4: Digit k shows word bits [3k+2:3k] for k = 0 to 4. Digit 5 shows bit 15 zero-extended to three bits, so it can only show 0 or 1.
- R5: seg is active-high, with bit 0 = segment a up to bit 6 = segment g. Octal values 0 to 7 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07 (hex).
- R6: seg, dig_en and scan_idx change only at a step edge. The digit value is taken from the word held just before that edge.
- R7: rd_addr always carries 077576 octal.
- R8: A request becomes pending after reset and at every wrap from step 5 to step 0. rd_req is high exactly when a request is pending and host_busy is low.
- R9: A cycle with rd_req and rd_gnt both high stores rd_data and clears the pending request. The new word appears on the digits from the next step edge onward.
- R10: While no grant is taken, the held word and the pending request are both kept. rd_gnt without rd_req has no effect.
- R11: If a grant is taken in the same cycle as a 5-to-0 wrap, the request stays pending for the new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_busy | input | 1 | Host is using memory; holds the read request back |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | ADDR_W | Fixed fetch address, 077576 octal |
| rd_gnt | input | 1 | Read grant; rd_data is valid in the same cycle |
| rd_data | input | WORD_W | Word returned by memory |
| seg | output | 7 | Segments a..g, active high, bit 0 = a |
| dig_en | output | NUM_DIG | One-hot digit enable |
| scan_idx | output | IDX_W | Current step number, for keypad scanning |

## Verification
The corner that is hardest to reach from the ports is a grant taken on the very edge where the sweep wraps from 5 to 0. At that edge the pending request must survive, and the digit latched in that cycle must still come from the old word.

The bench reaches this edge in two ways. It runs long stretches with host_busy held high or rd_gnt held low, so a request is still waiting when the wrap arrives. It then releases the port at varying phases relative to the sweep.

A behavioural model tracks the pending flag and the held word through every one of these cycles. It also feeds all-ones and single-top-bit words, to check that the top digit shows only bit 15.

// File: rtl/oct_disp_pkg.sv
package oct_disp_pkg;

   localparam int SEG_W = 7;
   localparam int OCT_W = 3;

   typedef logic [SEG_W-1:0] seg_t;
   typedef logic [OCT_W-1:0] oct_t;

   // bit 0 = a ... bit 6 = g, active high
   function automatic seg_t oct_to_seg(input oct_t v);
      seg_t s;
      case (v)
         3'd0:    s = 7'h3F;
         3'd1:    s = 7'h06;
         3'd2:    s = 7'h5B;
         3'd3:    s = 7'h4F;
         3'd4:    s = 7'h66;
         3'd5:    s = 7'h6D;
         3'd6:    s = 7'h7D;
         default: s = 7'h07;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ods_step_timer.sv
module ods_step_timer #(
   parameter int STEP_CLKS = 1024,
   parameter int NUM_DIG   = 6,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tick_o,
   output logic             wrap_o,
   output logic [IDX_W-1:0] nxt_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIG - 1);

   logic [IDX_W-1:0] step_q;

   generate
      if (STEP_CLKS == 1) begin : g_every_clk
         assign tick_o = 1'b1;
      end else begin : g_prescale
         localparam int CNT_W = $clog2(STEP_CLKS);
         localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_CLKS - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (cnt_q == CNT_END) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == CNT_END);
      end
   endgenerate

   assign nxt_o  = (step_q == LAST) ? '0 : step_q + 1'b1;
   assign wrap_o = tick_o && (step_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      step_q <= '0;
      else if (tick_o) step_q <= nxt_o;
   end
endmodule

// File: rtl/ods_word_fetch.sv
module ods_word_fetch #(
   parameter int                WORD_W     = 16,
   parameter int                ADDR_W     = 15,
   parameter logic [ADDR_W-1:0] FETCH_ADDR = 15'o77576
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sweep_end_i,
   input  logic              host_busy,
   input  logic              rd_gnt,
   input  logic [WORD_W-1:0] rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] word_o
);
   logic pend_q;
   logic take;

   assign rd_req  = pend_q && !host_busy;
   assign take    = rd_req && rd_gnt;
   assign rd_addr = FETCH_ADDR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b1;
         word_o <= '0;
      end else begin
         if (take)             word_o <= rd_data;
         if (sweep_end_i)      pend_q <= 1'b1;
         else if (take)        pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ods_digit_driver.sv
module ods_digit_driver
   import oct_disp_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int NUM_DIG = 6,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [IDX_W-1:0]   idx_nxt_i,
   input  logic [WORD_W-1:0]  word_i,
   output seg_t               seg_o,
   output logic [NUM_DIG-1:0] den_o,
   output logic [IDX_W-1:0]   idx_o
);
   localparam int PAD_W = NUM_DIG * OCT_W;

   logic [PAD_W-1:0]   padded;
   oct_t               grp [NUM_DIG];
   oct_t               sel;
   logic [NUM_DIG-1:0] den_nxt;

   generate
      if (PAD_W > WORD_W) begin : g_pad
         assign padded = {{(PAD_W - WORD_W){1'b0}}, word_i};
      end else begin : g_exact
         assign padded = word_i;
      end
      for (genvar d = 0; d < NUM_DIG; d++) begin : g_grp
         assign grp[d] = padded[d*OCT_W +: OCT_W];
      end
   endgenerate

   always_comb begin
      sel     = '0;
      den_nxt = '0;
      for (int d = 0; d < NUM_DIG; d++) begin
         if (idx_nxt_i == IDX_W'(d)) begin
            sel        = grp[d];
            den_nxt[d] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_o <= oct_to_seg('0);
         den_o <= NUM_DIG'(1);
         idx_o <= '0;
      end else if (load_i) begin
         seg_o <= oct_to_seg(sel);
         den_o <= den_nxt;
         idx_o <= idx_nxt_i;
      end
   end
endmodule

// File: rtl/oct_disp_scan.sv
module oct_disp_scan
   import oct_disp_pkg::*;
#(
   parameter int                WORD_W     = 16,
   parameter int                NUM_DIG    = 6,
   parameter int                STEP_CLKS  = 1024,
   parameter int                ADDR_W     = 15,
   parameter logic [ADDR_W-1:0] FETCH_ADDR = 15'o77576,
   localparam int               IDX_W      = $clog2(NUM_DIG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_busy,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_gnt,
   input  logic [WORD_W-1:0]  rd_data,
   output logic [SEG_W-1:0]   seg,
   output logic [NUM_DIG-1:0] dig_en,
   output logic [IDX_W-1:0]   scan_idx
);
   generate
      if (NUM_DIG < 2) begin : g_bad_ndig
         $error("oct_disp_scan: NUM_DIG must be at least 2");
      end
      if (NUM_DIG * OCT_W < WORD_W || NUM_DIG * OCT_W - WORD_W >= OCT_W) begin : g_bad_fit
         $error("oct_disp_scan: every digit must hold at least one word bit");
      end
      if (STEP_CLKS < 1) begin : g_bad_step
         $error("oct_disp_scan: STEP_CLKS must be at least 1");
      end
   endgenerate

   logic             tick;
   logic             sweep_end;
   logic [IDX_W-1:0] idx_nxt;
   logic [WORD_W-1:0] shown_word;

   ods_step_timer #(
      .STEP_CLKS (STEP_CLKS),
      .NUM_DIG   (NUM_DIG),
      .IDX_W     (IDX_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick),
      .wrap_o (sweep_end),
      .nxt_o  (idx_nxt)
   );

   ods_word_fetch #(
      .WORD_W     (WORD_W),
      .ADDR_W     (ADDR_W),
      .FETCH_ADDR (FETCH_ADDR)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .sweep_end_i (sweep_end),
      .host_busy   (host_busy),
      .rd_gnt      (rd_gnt),
      .rd_data     (rd_data),
      .rd_req      (rd_req),
      .rd_addr     (rd_addr),
      .word_o      (shown_word)
   );

   ods_digit_driver #(
      .WORD_W  (WORD_W),
      .NUM_DIG (NUM_DIG),
      .IDX_W   (IDX_W)
   ) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tick),
      .idx_nxt_i (idx_nxt),
      .word_i    (shown_word),
      .seg_o     (seg),
      .den_o     (dig_en),
      .idx_o     (scan_idx)
   );
endmodule

// File: rtl/oct_disp_scan_chk.sv
module oct_disp_scan_chk #(
   parameter int WORD_W    = 16,
   parameter int NUM_DIG   = 6,
   parameter int STEP_CLKS = 1024,
   parameter int IDX_W     = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_busy,
   input logic               rd_req,
   input logic               rd_gnt,
   input logic [WORD_W-1:0]  word,
   input logic [6:0]         seg,
   input logic [NUM_DIG-1:0] dig_en,
   input logic [IDX_W-1:0]   scan_idx
);
   localparam int CW = $clog2(STEP_CLKS + 1);
   localparam logic [CW-1:0]    CK_END = CW'(STEP_CLKS - 1);
   localparam logic [IDX_W-1:0] LAST   = IDX_W'(NUM_DIG - 1);

   logic [CW-1:0] ck_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ck_cnt <= '0;
      else if (ck_cnt == CK_END)  ck_cnt <= '0;
      else                        ck_cnt <= ck_cnt + 1'b1;
   end

   AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dig_en) == 1); // R3
   AST_DEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      dig_en[scan_idx] == 1'b1); // R3
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_idx <= LAST); // R2
   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scan_idx) |-> scan_idx == (($past(scan_idx) == LAST) ? '0 : $past(scan_idx) + 1'b1)); // R2
   AST_PACE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_cnt == CK_END) |=> !$stable(scan_idx)); // R2
   AST_PACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_cnt != CK_END) |=> $stable(scan_idx)); // R6
   AST_SEG_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seg) |-> !$stable(scan_idx)); // R6
   AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !host_busy); // R8
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && rd_gnt) |=> $stable(word)); // R10
endmodule

bind oct_disp_scan oct_disp_scan_chk #(
   .WORD_W    (WORD_W),
   .NUM_DIG   (NUM_DIG),
   .STEP_CLKS (STEP_CLKS),
   .IDX_W     (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_busy (host_busy),
   .rd_req    (rd_req),
   .rd_gnt    (rd_gnt),
   .word      (shown_word),
   .seg       (seg),
   .dig_en    (dig_en),
   .scan_idx  (scan_idx)
);

// File: tb/tb_oct_disp_scan.sv
`timescale 1ns/1ps
module tb_oct_disp_scan;
   localparam int P = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_busy, rd_gnt;
   logic [15:0] rd_data;
   logic        rd_req;
   logic [14:0] rd_addr;
   logic [6:0]  seg;
   logic [5:0]  dig_en;
   logic [2:0]  scan_idx;

   int vec = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   oct_disp_scan #(.STEP_CLKS(P)) dut (
      .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_data(rd_data),
      .seg(seg), .dig_en(dig_en), .scan_idx(scan_idx));

   // glyph table from R5
   logic [6:0] glyph [8];
   initial begin
      glyph[0] = 7'h3F; glyph[1] = 7'h06; glyph[2] = 7'h5B; glyph[3] = 7'h4F;
      glyph[4] = 7'h66; glyph[5] = 7'h6D; glyph[6] = 7'h7D; glyph[7] = 7'h07;
   end

   // behavioural model
   int          m_cnt = 0, m_step = 0;
   logic [15:0] m_word = '0;
   bit          m_pend = 1;
   logic [6:0]  e_seg = 7'h3F;
   logic [5:0]  e_den = 6'b000001;
   int          e_idx = 0;
   int          r11_hits = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_step = 0; m_word = '0; m_pend = 1;
         e_seg = 7'h3F; e_den = 6'b000001; e_idx = 0;
      end else begin
         logic [15:0] old;
         bit took;
         old  = m_word;
         took = m_pend && !host_busy && rd_gnt;
         if (took) begin m_word = rd_data; m_pend = 0; end
         if (m_cnt == P-1) begin
            int nx;
            m_cnt = 0;
            nx = (m_step == 5) ? 0 : m_step + 1;
            if (m_step == 5) begin
               m_pend = 1;
               if (took) r11_hits++;
            end
            m_step = nx;
            e_idx  = nx;
            e_den  = 6'(1 << nx);
            e_seg  = glyph[(int'(old) >> (3*nx)) & 7];
         end else m_cnt++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_reset();
      chk(scan_idx == 0, "R1 scan_idx", scan_idx, 0);
      chk(dig_en == 6'b000001, "R1 dig_en", dig_en, 1);
      chk(seg == 7'h3F, "R1 seg", seg, 7'h3F);
      chk(rd_req == !host_busy, "R1 R8 pending after reset", rd_req, !host_busy);
   endtask

   initial begin
      rst_n = 0; host_busy = 0; rd_gnt = 0; rd_data = '0;
      repeat (3) @(negedge clk);
      chk_reset();
      rst_n = 1;
      for (int cyc = 0; cyc < 2600; cyc++) begin
         @(negedge clk);
         if (rst_n) begin
            chk(seg == e_seg, "R4 R5 R6 R9 R10 R11 seg", seg, e_seg);
            chk(dig_en == e_den, "R3 dig_en", dig_en, e_den);
            chk(int'(scan_idx) == e_idx, "R2 scan_idx", scan_idx, e_idx);
            chk(rd_addr == 15'o77576, "R7 rd_addr", rd_addr, 15'o77576);
         end
         if (cyc >= 1400 && cyc < 1403) begin
            rst_n = 0;
         end else if (cyc == 1403) begin
            chk_reset();
            rst_n = 1;
         end
         if (cyc < 500) begin
            host_busy = ($urandom % 4) == 0;
            rd_gnt    = $urandom % 2;
            rd_data   = 16'($urandom);
         end else if (cyc < 800) begin
            host_busy = 1; rd_gnt = 1; rd_data = 16'($urandom);   // R10 held back
         end else if (cyc < 1100) begin
            host_busy = 0; rd_gnt = 0; rd_data = 16'($urandom);   // R10 no grant
         end else if (cyc < 1400) begin
            host_busy = (cyc % 29) < 20; rd_gnt = 1;               // R11 phases
            case ((cyc / 24) % 4)
               0: rd_data = 16'o177777;
               1: rd_data = 16'o100000;
               2: rd_data = 16'o052525;
               default: rd_data = 16'o000000;
            endcase
         end else begin
            host_busy = ($urandom % 3) == 0;
            rd_gnt    = (cyc % 37) > 30;
            rd_data   = 16'($urandom);
         end
         #1;
         if (rst_n)
            chk(rd_req == (m_pend && !host_busy), "R8 rd_req", rd_req, m_pend && !host_busy);
      end
      chk(r11_hits > 0, "R11 grant on wrap edge reached", r11_hits, 1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         vec++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end
endmodule